// File: doc/BRIEF.md
# Clock-Settling Watchdog Sequencer

This block is an 8-bit up-counting watchdog that doubles as an oscillator settling timer. It runs from an always-on oscillator clock, so the count can advance while the system clock is gated off. Software loads an initial count and picks a prescale ratio through a small keyed register interface.

In normal operation, with the timer enabled, counter overflow raises either a one-cycle reset pulse or a one-cycle interval interrupt, and it sets a sticky overflow flag. The second role covers two cases: leaving standby, and a frequency change. In both cases the block drops its clock-supply request. It then times a settling period, starting from a wake edge on the NMI input or from a write to the frequency register. When the count overflows, the request is raised again. A settling overflow never sets the flag. After a frequency change the counter parks at zero until software reloads it.

Top module: `settle_wdog`

## Requirements
- R1: After reset, sys_clk_en is 1, wdt_rst and wdt_irq are 0, and both the counter (rd_addr=0) and the control register (rd_addr=1) read 0x00.
- R2: The control field sel, in bits [2:0], selects the count rate. Values 0 to 7 give one increment every 1, 4, 16, 32, 64, 256, 1024 or 4096 cycles. The prescaler restarts on every counter load and at every settling start.
- R3: A write with wr_addr=0 loads the counter from wr_data[7:0] only when wr_data[15:8]=0x5A. A write with wr_addr=1 updates the control register only when wr_data[15:8]=0xA5. A write with any other key changes nothing.
- R4: The control register holds en in bit 5, mode in bit 6 and flag in bit 7. When the timer is enabled and running normally, an overflow from 0xFF sets flag. It also pulses wdt_rst for one cycle if mode=0, or wdt_irq for one cycle if mode=1. A control write with bit 7 = 0 clears flag.
- R5: While running normally with en=0, the counter holds its value and no pulse is produced.
- R6: A stby_req pulse with deep_stby=0 drops sys_clk_en on the next cycle. With deep_stby=1 the request is ignored and sys_clk_en stays 1.
- R7: In standby, the counter does not advance until a rising edge on nmi. That edge starts the settling count, and sys_clk_en stays low for exactly (256 - initial count) x ratio cycles.
- R8: A freq_wr pulse during normal running drops sys_clk_en and starts the settling count at once. sys_clk_en stays low for exactly (256 - initial count) x ratio cycles.
- R9: An overflow that ends a settling period leaves flag clear and produces no wdt_rst or wdt_irq pulse.
- R10: After a frequency-change settling overflow, the counter reads 0x00 and stays there, even with en=1, until a keyed counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the counter, 1 selects control |
| wr_data | input | 16 | Key in [15:8], value in [7:0] |
| rd_addr | input | 1 | Read select: 0 counter, 1 control |
| rd_data | output | 8 | Read data for the selected register |
| stby_req | input | 1 | Pulse requesting entry to standby |
| deep_stby | input | 1 | Deep standby selected; the request is then ignored |
| nmi | input | 1 | Wake input; a rising edge ends the standby wait |
| freq_wr | input | 1 | Pulse marking a write to the frequency register |
| sys_clk_en | output | 1 | System clock supply request |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| wdt_irq | output | 1 | One-cycle interval interrupt pulse |

## Verification
The bench builds the block with its default 8-bit counter and 12-bit prescaler. It loads initial counts only two or three steps below overflow, so every one of the eight prescale ratios, up to /4096, can be timed cycle-exactly within a short run. It sweeps all eight ratios through normal overflow, standby wake and frequency change, alternating the overflow mode. Expected durations are computed as steps times ratio.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STBY = 2'd2,
    ST_FREQ = 2'd3
  } swd_state_e;

  // log2 of the prescale ratio picked by the 3-bit select
  function automatic int unsigned sel_shift(input logic [2:0] sel);
    case (sel)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 8;
      3'd6: return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/swd_prescale.sv
module swd_prescale #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  import swd_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = (PRE_W'(1) << sel_shift(sel)) - PRE_W'(1);
    tick = ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + PRE_W'(1);
  end

  assert_div1_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |-> tick);
endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap = inc && !load && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + CNT_W'(1);
  end

  assert_wrap_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/swd_seq.sv
module swd_seq (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stby_req,
  input  logic                 deep_stby,
  input  logic                 nmi,
  input  logic                 freq_wr,
  input  logic                 cnt_wrap,
  input  logic                 cnt_load,
  output swd_pkg::swd_state_e  state,
  output logic                 clk_en,
  output logic                 settle_start,
  output logic                 settle_ovf,
  output logic                 parked
);
  import swd_pkg::*;

  swd_state_e state_d;
  logic       nmi_q;
  logic       nmi_rise;

  assign nmi_rise   = nmi && !nmi_q;
  assign settle_ovf = ((state == ST_STBY) || (state == ST_FREQ)) && cnt_wrap;

  always_comb begin
    state_d      = state;
    settle_start = 1'b0;
    case (state)
      ST_RUN: begin
        if (freq_wr) begin
          state_d      = ST_FREQ;
          settle_start = 1'b1;
        end else if (stby_req && !deep_stby) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (nmi_rise) begin
          state_d      = ST_STBY;
          settle_start = 1'b1;
        end
      end
      ST_STBY: if (cnt_wrap) state_d = ST_RUN;
      default: if (cnt_wrap) state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      clk_en <= 1'b1;
      nmi_q  <= 1'b0;
      parked <= 1'b0;
    end else begin
      state  <= state_d;
      clk_en <= (state_d == ST_RUN);
      nmi_q  <= nmi;
      if (state == ST_FREQ && cnt_wrap) parked <= 1'b1;
      else if (cnt_load)                parked <= 1'b0;
    end
  end

  assert_clk_back_only_on_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(settle_ovf));
  assert_deep_req_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && stby_req && deep_stby && !freq_wr) |=> clk_en);
  assert_freq_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && freq_wr) |=> !clk_en);
endmodule

// File: rtl/settle_wdog.sv
module settle_wdog #(
  parameter int         CNT_W   = 8,
  parameter int         PRE_W   = 12,
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_CTL = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_addr,
  output logic [7:0]  rd_data,
  input  logic        stby_req,
  input  logic        deep_stby,
  input  logic        nmi,
  input  logic        freq_wr,
  output logic        sys_clk_en,
  output logic        wdt_rst,
  output logic        wdt_irq
);
  import swd_pkg::*;

  logic [2:0]       sel_q;
  logic             en_q;
  logic             mode_q;
  logic             flag_q;
  logic             cnt_load;
  logic             ctl_load;
  logic             tick;
  logic             inc;
  logic             wrap;
  logic             wd_ovf;
  logic             settle_start;
  logic             settle_ovf;
  logic             parked;
  logic [CNT_W-1:0] cnt;
  swd_state_e       state;

  assign cnt_load = wr_en && !wr_addr && (wr_data[15:8] == KEY_CNT);
  assign ctl_load = wr_en &&  wr_addr && (wr_data[15:8] == KEY_CTL);

  assign inc = tick && ((state == ST_STBY) || (state == ST_FREQ) ||
                        (state == ST_RUN && en_q && !parked));
  assign wd_ovf = (state == ST_RUN) && wrap;

  swd_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_load || settle_start),
    .sel(sel_q), .tick(tick)
  );

  swd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load),
    .load_val(wr_data[CNT_W-1:0]), .inc(inc), .cnt(cnt), .wrap(wrap)
  );

  swd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .deep_stby(deep_stby),
    .nmi(nmi), .freq_wr(freq_wr), .cnt_wrap(wrap), .cnt_load(cnt_load),
    .state(state), .clk_en(sys_clk_en), .settle_start(settle_start),
    .settle_ovf(settle_ovf), .parked(parked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      flag_q  <= 1'b0;
      wdt_rst <= 1'b0;
      wdt_irq <= 1'b0;
    end else begin
      if (ctl_load) begin
        sel_q  <= wr_data[2:0];
        en_q   <= wr_data[5];
        mode_q <= wr_data[6];
      end
      if (wd_ovf)                      flag_q <= 1'b1;
      else if (ctl_load && !wr_data[7]) flag_q <= 1'b0;
      wdt_rst <= wd_ovf && !mode_q;
      wdt_irq <= wd_ovf &&  mode_q;
    end
  end

  always_comb begin
    if (rd_addr) rd_data = {flag_q, mode_q, en_q, 2'b00, sel_q};
    else         rd_data = 8'(cnt);
  end

  assert_settle_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_ovf && !flag_q) |=> !flag_q);
  assert_settle_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_ovf |=> (!wdt_rst && !wdt_irq));
  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wdt_rst, wdt_irq}));
  assert_rst_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  assert_irq_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |=> !wdt_irq);
  assert_parked_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !cnt_load) |=> (cnt == '0));
endmodule

// File: tb/sim_settle_wdog.sv
module sim_settle_wdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [7:0]  rd_data;
  logic        stby_req = 1'b0;
  logic        deep_stby = 1'b0;
  logic        nmi = 1'b0;
  logic        freq_wr = 1'b0;
  logic        sys_clk_en;
  logic        wdt_rst;
  logic        wdt_irq;

  int n_tests = 0;
  int n_fail  = 0;

  settle_wdog u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stby_req(stby_req), .deep_stby(deep_stby), .nmi(nmi),
    .freq_wr(freq_wr), .sys_clk_en(sys_clk_en), .wdt_rst(wdt_rst),
    .wdt_irq(wdt_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratio_of(input int s);
    int r = 1;
    case (s)
      0: r = 1;     1: r = 4;     2: r = 16;   3: r = 32;
      4: r = 64;    5: r = 256;   6: r = 1024; default: r = 4096;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change just after a falling edge; strobes last one cycle
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; freq_wr = 0; stby_req = 0;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] key, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = {key, v};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // count falling edges with sys_clk_en low; strobe already applied
  task automatic count_halt(output int n, output int pulses);
    n = 0; pulses = 0;
    forever begin
      @(negedge clk);
      wr_en = 0; freq_wr = 0; stby_req = 0;
      if (wdt_rst || wdt_irq) pulses++;
      if (sys_clk_en || n > 20000) break;
      n++;
    end
  endtask

  initial begin
    int v, n, p, k, want_irq;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 clk_en", int'(sys_clk_en), 1);
    check("R1 pulses", int'(wdt_rst) + int'(wdt_irq), 0);
    rd(0, v); check("R1 counter", v, 0);
    rd(1, v); check("R1 control", v, 0);

    // R3 keyed writes
    wr(0, 8'h11, 8'h33); rd(0, v); check("R3 bad counter key", v, 0);
    wr(0, 8'h5A, 8'h33); rd(0, v); check("R3 counter load", v, 8'h33);
    idle(50); rd(0, v); check("R5 disabled holds", v, 8'h33);
    wr(1, 8'h5B, 8'h62); rd(1, v); check("R3 bad control key", v, 0);
    wr(1, 8'hA5, 8'h42); rd(1, v); check("R3 control load", v, 8'h42);

    // R2/R4 normal overflow, all ratios, alternating mode
    for (int s = 0; s < 8; s++) begin
      k = (s < 4) ? 3 : 2;
      want_irq = s % 2;
      wr(1, 8'hA5, 8'(s) | 8'h20 | (want_irq ? 8'h40 : 8'h00));
      @(negedge clk);
      wr_en = 1; wr_addr = 0; wr_data = {8'h5A, 8'(256 - k)};
      n = 0;
      forever begin
        @(negedge clk);
        wr_en = 0;
        if (wdt_rst || wdt_irq || n > 20000) break;
        n++;
      end
      check($sformatf("R2 ratio sel=%0d", s), n, k * ratio_of(s));
      check("R4 pulse kind", int'(wdt_irq), want_irq);
      check("R4 other pulse", int'(wdt_rst), 1 - want_irq);
      @(negedge clk);
      check("R4 pulse width", int'(wdt_rst) + int'(wdt_irq), 0);
      rd(1, v); check("R4 flag set", (v >> 7) & 1, 1);
      wr(1, 8'hA5, 8'h00); rd(1, v); check("R4 flag clear", v, 0);
    end

    // R6 deep standby ignored
    deep_stby = 1;
    @(negedge clk); stby_req = 1;
    idle(5); check("R6 deep ignored", int'(sys_clk_en), 1);
    deep_stby = 0;

    // R7 standby wake by nmi edge, all ratios
    for (int s = 0; s < 8; s++) begin
      wr(1, 8'hA5, 8'(s));
      wr(0, 8'h5A, 8'hFE);
      @(negedge clk); stby_req = 1;
      @(negedge clk); stby_req = 0;
      check("R6 standby halts", int'(sys_clk_en), 0);
      idle(20);
      check("R7 waits for nmi", int'(sys_clk_en), 0);
      rd(0, v); check("R7 no count before nmi", v, 8'hFE);
      nmi = 1;
      count_halt(n, p);
      check($sformatf("R7 settle sel=%0d", s), n, 2 * ratio_of(s));
      check("R9 no pulse stby", p, 0);
      rd(1, v); check("R9 flag clear stby", (v >> 7) & 1, 0);
      nmi = 0;
      idle(2);
    end

    // R8/R10 frequency change settling, all ratios
    for (int s = 0; s < 8; s++) begin
      wr(1, 8'hA5, 8'(s));
      wr(0, 8'h5A, 8'hFD);
      @(negedge clk); freq_wr = 1;
      count_halt(n, p);
      check($sformatf("R8 settle sel=%0d", s), n, 3 * ratio_of(s));
      check("R9 no pulse freq", p, 0);
      rd(1, v); check("R9 flag clear freq", (v >> 7) & 1, 0);
      rd(0, v); check("R10 parked zero", v, 0);
      wr(1, 8'hA5, 8'h20);
      p = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (wdt_rst || wdt_irq) p++;
      end
      rd(0, v); check("R10 stays zero enabled", v, 0);
      check("R10 no pulse parked", p, 0);
      wr(1, 8'hA5, 8'h00);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule